// File: doc/BRIEF.md
# Digital Pattern Output Engine

This block drives a port of digital lines from a sample FIFO. A loader pushes samples through a simple write port, which takes the place of a memory-transfer stream. A sample clock is picked from several internal clocks or an external pin. It is synchronized into the system clock domain, and its chosen edge becomes a one-cycle update strobe. Each strobe takes one sample and presents it on the lines that are set to waveform output. Each line is set on its own to input (undriven), static output, or waveform output.

A small controller has three states. `ST_IDLE` ignores strobes. `ST_STREAM` drains the FIFO one sample per strobe. `ST_REPLAY` walks the stored samples in order, without removing them, and wraps back to the oldest sample forever.

The transitions are:
- From `ST_IDLE` to `ST_STREAM` when `run` is high and `retransmit` is low.
- From `ST_IDLE` to `ST_REPLAY` when `run` and `retransmit` are both high and the FIFO is not empty.
- From `ST_STREAM` or `ST_REPLAY` back to `ST_IDLE` when `run` falls.

The mode is therefore chosen only when leaving `ST_IDLE`. A strobe in `ST_STREAM` with an empty FIFO raises a sticky underflow flag and leaves the lines as they were.

Top module: `pattern_out_engine`

## Requirements
- R1: After reset, `dio_out` and `dio_oe` are 0, `fifo_count` is 0, `fifo_empty` is 1, `fifo_full` is 0 and `underflow` is 0.
- R2: A write (`wr_en` high for one cycle) stores `wr_data` and raises `fifo_count` by one. A write is ignored while `fifo_count` equals DEPTH. `fifo_full` is high exactly at DEPTH entries, and `fifo_empty` is high exactly at zero entries.
- R3: In `ST_STREAM`, each update event removes the oldest stored sample, shows it on the waveform lines and lowers `fifo_count` by one. Samples come out in write order. Lines change at the third rising `clk` edge after the selected source makes the chosen transition.
- R4: With `falling_sel` = 0 an event is a low-to-high transition of the selected source. With `falling_sel` = 1 it is a high-to-low transition. The other transition has no effect.
- R5: `clk_sel` values 0 to 4 pick `int_clks[clk_sel]`. Index 0 is the digital-input sample clock, 1 the analog-input sample clock, 2 the analog convert clock, 3 the analog-output sample clock and 4 the counter sample clock. Any value of 5 or above picks `ext_clk`. Transitions on a source that is not selected have no effect.
- R6: In `ST_STREAM`, an event with an empty FIFO sets `underflow`, and `dio_out` and `fifo_count` stay unchanged. `underflow` stays high until `underflow_clr` is high for a cycle. A new underflow in the same cycle as a clear wins over the clear.
- R7: In `ST_REPLAY`, each event shows the next stored sample. After the newest sample it wraps to the oldest, so a store of A, B, C gives A, B, C, A, B, C, and so on. `fifo_count` does not change.
- R8: Writes are ignored in `ST_REPLAY`. After leaving replay, the stored samples are still held, and a later stream starts from the oldest of them.
- R9: Line i is configured by `line_cfg[2i+1:2i]`:
  - 00: input, with `dio_oe[i]` = 0 and `dio_out[i]` = 0.
  - 01: static output, with `dio_out[i]` = `static_data[i]` and `dio_oe[i]` = 1.
  - 10: waveform output, with `dio_out[i]` = bit i of the last presented sample and `dio_oe[i]` = 1.
  - 11: behaves as input.
- R10: In `ST_IDLE`, events are ignored: nothing is removed, nothing is shown and no underflow is raised. With `run` and `retransmit` high and an empty FIFO, the engine waits in `ST_IDLE` until a sample is written, then replays.
- R11: Waveform lines hold their value between events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | WIDTH | Sample to store |
| fifo_full | output | 1 | FIFO holds DEPTH samples |
| fifo_empty | output | 1 | FIFO holds no samples |
| fifo_count | output | $clog2(DEPTH+1) | Stored sample count |
| int_clks | input | NUM_INT_CLK | Internal sample clock candidates |
| ext_clk | input | 1 | External sample clock pin |
| clk_sel | input | $clog2(NUM_INT_CLK+1) | Sample clock source select |
| falling_sel | input | 1 | 1 = update on the falling transition |
| run | input | 1 | Enable pattern output |
| retransmit | input | 1 | Loop over the stored pattern |
| line_cfg | input | 2*WIDTH | Per-line mode fields |
| static_data | input | WIDTH | Values for static-output lines |
| underflow | output | 1 | Sticky empty-FIFO event flag |
| underflow_clr | input | 1 | Clears `underflow` |
| dio_out | output | WIDTH | Line output values |
| dio_oe | output | WIDTH | Line output enables |

## Verification
An event's result is due at the third rising `clk` edge after the source transition: two synchronizer flops, then the sample register. The bench changes a source on a falling `clk` edge, waits four falling edges, and only then samples. Writes take effect at the next rising edge, so `fifo_count` and the flags are read one falling edge after `wr_en` drops. Line modes and static data act with no delay and are read in the same wait. Changes to `run` are given two cycles to move the controller before any event is sent.

// File: rtl/pat_pkg.sv
package pat_pkg;

    typedef enum logic [1:0] {
        LM_INPUT  = 2'b00,
        LM_STATIC = 2'b01,
        LM_WAVE   = 2'b10,
        LM_RSVD   = 2'b11
    } line_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_STREAM = 2'b01,
        ST_REPLAY = 2'b10
    } eng_state_e;

    // returns {output enable, output value}
    function automatic logic [1:0] line_drive(input line_mode_e m,
                                              input logic st,
                                              input logic wv);
        logic [1:0] r;
        unique case (m)
            LM_STATIC: r = {1'b1, st};
            LM_WAVE:   r = {1'b1, wv};
            default:   r = 2'b00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pat_clk_strobe.sv
module pat_clk_strobe #(
    parameter int NUM_INT = 5,
    parameter int SELW    = $clog2(NUM_INT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_INT-1:0] int_clks,
    input  logic               ext_clk,
    input  logic [SELW-1:0]    clk_sel,
    input  logic               falling_sel,
    output logic               strobe
);

    logic       src;
    logic [2:0] sh;

    always_comb begin
        src = ext_clk;
        for (int i = 0; i < NUM_INT; i++) begin
            if (clk_sel == SELW'(i)) begin
                src = int_clks[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= {sh[1:0], src};
        end
    end

    assign strobe = falling_sel ? (sh[2] & ~sh[1]) : (~sh[2] & sh[1]);

endmodule

// File: rtl/pat_fifo.sv
module pat_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    input  logic             rp_load,
    input  logic             rp_adv,
    input  logic             replay_sel,
    output logic [WIDTH-1:0] head_data,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr, rp;
    logic [CW-1:0]    k;
    logic             push_ok;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push & ~full;

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= nxt(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= nxt(rd_ptr);
            end
            unique case ({push_ok, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp <= '0;
            k  <= '0;
        end else if (rp_load) begin
            rp <= rd_ptr;
            k  <= '0;
        end else if (rp_adv) begin
            if (k == count - CW'(1)) begin
                rp <= rd_ptr;
                k  <= '0;
            end else begin
                rp <= nxt(rp);
                k  <= k + 1'b1;
            end
        end
    end

    assign head_data = replay_sel ? mem[rp] : mem[rd_ptr];

endmodule

// File: rtl/pat_ctrl.sv
module pat_ctrl
    import pat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       retransmit,
    input  logic       strobe,
    input  logic       empty,
    input  logic       uf_clr,
    output logic       pop,
    output logic       rp_load,
    output logic       rp_adv,
    output logic       load_sample,
    output logic       replay_act,
    output logic       underflow,
    output eng_state_e state
);

    eng_state_e state_nx;
    logic       uf_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (run && !retransmit) begin
                    state_nx = ST_STREAM;
                end else if (run && retransmit && !empty) begin
                    state_nx = ST_REPLAY;
                end
            end
            ST_STREAM: if (!run) state_nx = ST_IDLE;
            ST_REPLAY: if (!run) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        pop         = 1'b0;
        rp_load     = 1'b0;
        rp_adv      = 1'b0;
        load_sample = 1'b0;
        uf_set      = 1'b0;
        replay_act  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                rp_load = run && retransmit && !empty;
            end
            ST_STREAM: begin
                if (run && strobe) begin
                    pop         = !empty;
                    load_sample = !empty;
                    uf_set      = empty;
                end
            end
            ST_REPLAY: begin
                replay_act  = 1'b1;
                rp_adv      = run && strobe;
                load_sample = run && strobe;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            underflow <= 1'b0;
        end else if (uf_set) begin
            underflow <= 1'b1;
        end else if (uf_clr) begin
            underflow <= 1'b0;
        end
    end

endmodule

// File: rtl/pat_pins.sv
module pat_pins
    import pat_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [WIDTH-1:0]   sample,
    input  logic [2*WIDTH-1:0] line_cfg,
    input  logic [WIDTH-1:0]   static_data,
    output logic [WIDTH-1:0]   dio_out,
    output logic [WIDTH-1:0]   dio_oe
);

    logic [WIDTH-1:0] wave_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wave_q <= '0;
        end else if (load) begin
            wave_q <= sample;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        assign {dio_oe[i], dio_out[i]} =
            line_drive(line_mode_e'(line_cfg[2*i +: 2]), static_data[i], wave_q[i]);
    end

endmodule

// File: rtl/pattern_out_engine.sv
module pattern_out_engine
    import pat_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int DEPTH       = 16,
    parameter int NUM_INT_CLK = 5,
    localparam int CW         = $clog2(DEPTH + 1),
    localparam int SELW       = $clog2(NUM_INT_CLK + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [WIDTH-1:0]       wr_data,
    output logic                   fifo_full,
    output logic                   fifo_empty,
    output logic [CW-1:0]          fifo_count,
    input  logic [NUM_INT_CLK-1:0] int_clks,
    input  logic                   ext_clk,
    input  logic [SELW-1:0]        clk_sel,
    input  logic                   falling_sel,
    input  logic                   run,
    input  logic                   retransmit,
    input  logic [2*WIDTH-1:0]     line_cfg,
    input  logic [WIDTH-1:0]       static_data,
    output logic                   underflow,
    input  logic                   underflow_clr,
    output logic [WIDTH-1:0]       dio_out,
    output logic [WIDTH-1:0]       dio_oe
);

    logic             strobe;
    logic             pop, rp_load, rp_adv, load_sample, replay_act;
    logic [WIDTH-1:0] head_data;
    eng_state_e       eng_state;

    pat_clk_strobe #(
        .NUM_INT (NUM_INT_CLK),
        .SELW    (SELW)
    ) u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .int_clks    (int_clks),
        .ext_clk     (ext_clk),
        .clk_sel     (clk_sel),
        .falling_sel (falling_sel),
        .strobe      (strobe)
    );

    pat_fifo #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (wr_en & ~replay_act),
        .wr_data    (wr_data),
        .pop        (pop),
        .rp_load    (rp_load),
        .rp_adv     (rp_adv),
        .replay_sel (replay_act),
        .head_data  (head_data),
        .count      (fifo_count),
        .full       (fifo_full),
        .empty      (fifo_empty)
    );

    pat_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .retransmit  (retransmit),
        .strobe      (strobe),
        .empty       (fifo_empty),
        .uf_clr      (underflow_clr),
        .pop         (pop),
        .rp_load     (rp_load),
        .rp_adv      (rp_adv),
        .load_sample (load_sample),
        .replay_act  (replay_act),
        .underflow   (underflow),
        .state       (eng_state)
    );

    pat_pins #(
        .WIDTH (WIDTH)
    ) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load_sample),
        .sample      (head_data),
        .line_cfg    (line_cfg),
        .static_data (static_data),
        .dio_out     (dio_out),
        .dio_oe      (dio_oe)
    );

endmodule

// File: rtl/pat_engine_checks.sv
module pat_engine_checks
    import pat_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               strobe,
    input logic               run,
    input logic               wr_en,
    input logic               pop,
    input logic               load_sample,
    input eng_state_e         eng_state,
    input logic [CW-1:0]      fifo_count,
    input logic               fifo_full,
    input logic               fifo_empty,
    input logic               underflow,
    input logic               underflow_clr,
    input logic [WIDTH-1:0]   dio_out,
    input logic [2*WIDTH-1:0] line_cfg,
    input logic [WIDTH-1:0]   static_data
);

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    a_r2_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full && !pop |=> fifo_full);

    a_r6_uf_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == ST_STREAM) && run && strobe && fifo_empty |=> underflow);

    a_r6_uf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow && !underflow_clr |=> underflow);

    a_r8_replay_count: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == ST_REPLAY) |=> $stable(fifo_count));

    a_r10_idle_no_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == ST_IDLE) && !wr_en |=> $stable(fifo_count));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_sample) && $stable(line_cfg) && $stable(static_data)
        |-> $stable(dio_out));

endmodule

bind pattern_out_engine pat_engine_checks #(
    .WIDTH (WIDTH),
    .DEPTH (DEPTH),
    .CW    (CW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe        (strobe),
    .run           (run),
    .wr_en         (wr_en),
    .pop           (pop),
    .load_sample   (load_sample),
    .eng_state     (eng_state),
    .fifo_count    (fifo_count),
    .fifo_full     (fifo_full),
    .fifo_empty    (fifo_empty),
    .underflow     (underflow),
    .underflow_clr (underflow_clr),
    .dio_out       (dio_out),
    .line_cfg      (line_cfg),
    .static_data   (static_data)
);

// File: tb/test_pattern_out_engine.sv
module test_pattern_out_engine;

    localparam int WIDTH = 8;
    localparam int DEPTH = 16;
    localparam int NINT  = 5;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int SELW  = $clog2(NINT + 1);

    // {line_cfg, static_data, sample, expected out, expected oe}
    localparam logic [47:0] VEC [6] = '{
        {16'hAAAA, 8'h00, 8'h5A, 8'h5A, 8'hFF},
        {16'h5555, 8'hC3, 8'hFF, 8'hC3, 8'hFF},
        {16'h0000, 8'hFF, 8'hFF, 8'h00, 8'h00},
        {16'hFFFF, 8'hFF, 8'hFF, 8'h00, 8'h00},
        {16'h55AA, 8'hA5, 8'h3C, 8'hAC, 8'hFF},
        {16'hFA50, 8'hFF, 8'hFF, 8'h3C, 8'h3C}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             fifo_full, fifo_empty;
    logic [CW-1:0]    fifo_count;
    logic [NINT-1:0]  int_clks = '0;
    logic             ext_clk = 1'b0;
    logic [SELW-1:0]  clk_sel = '0;
    logic             falling_sel = 1'b0;
    logic             run = 1'b0;
    logic             retransmit = 1'b0;
    logic [2*WIDTH-1:0] line_cfg = '0;
    logic [WIDTH-1:0] static_data = '0;
    logic             underflow;
    logic             underflow_clr = 1'b0;
    logic [WIDTH-1:0] dio_out, dio_oe;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pattern_out_engine #(
        .WIDTH       (WIDTH),
        .DEPTH       (DEPTH),
        .NUM_INT_CLK (NINT)
    ) i_pattern_out_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .fifo_full     (fifo_full),
        .fifo_empty    (fifo_empty),
        .fifo_count    (fifo_count),
        .int_clks      (int_clks),
        .ext_clk       (ext_clk),
        .clk_sel       (clk_sel),
        .falling_sel   (falling_sel),
        .run           (run),
        .retransmit    (retransmit),
        .line_cfg      (line_cfg),
        .static_data   (static_data),
        .underflow     (underflow),
        .underflow_clr (underflow_clr),
        .dio_out       (dio_out),
        .dio_oe        (dio_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_src(input int idx, input logic v);
        if (idx < NINT) int_clks[idx] = v;
        else ext_clk = v;
    endtask

    task automatic rise(input int idx);
        @(negedge clk);
        set_src(idx, 1'b1);
        repeat (4) @(negedge clk);
    endtask

    task automatic fall(input int idx);
        @(negedge clk);
        set_src(idx, 1'b0);
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input int idx);
        rise(idx);
        fall(idx);
    endtask

    task automatic push(input logic [WIDTH-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 dio_out", 32'(dio_out), 0);
        chk("R1 dio_oe", 32'(dio_oe), 0);
        chk("R1 count", 32'(fifo_count), 0);
        chk("R1 empty", 32'(fifo_empty), 1);
        chk("R1 full", 32'(fifo_full), 0);
        chk("R1 underflow", 32'(underflow), 0);

        // vector table: per-line modes (R9) through streaming (R3)
        run = 1'b1;
        settle();
        for (int i = 0; i < 6; i++) begin
            line_cfg    = VEC[i][47:32];
            static_data = VEC[i][31:24];
            push(VEC[i][23:16]);
            pulse(0);
            chk("R9 out", 32'(dio_out), 32'(VEC[i][15:8]));
            chk("R9 oe", 32'(dio_oe), 32'(VEC[i][7:0]));
        end

        // R3 order, R11 hold
        line_cfg    = 16'hAAAA;
        static_data = 8'h00;
        push(8'h11); push(8'h22); push(8'h33);
        chk("R2 count3", 32'(fifo_count), 3);
        rise(0);
        chk("R3 first", 32'(dio_out), 32'h11);
        fall(0);
        chk("R11 hold", 32'(dio_out), 32'h11);
        chk("R3 count2", 32'(fifo_count), 2);
        pulse(0);
        chk("R3 second", 32'(dio_out), 32'h22);
        pulse(0);
        chk("R3 third", 32'(dio_out), 32'h33);
        chk("R2 empty", 32'(fifo_empty), 1);

        // R6 underflow
        pulse(0);
        chk("R6 flag", 32'(underflow), 1);
        chk("R6 hold out", 32'(dio_out), 32'h33);
        chk("R6 count", 32'(fifo_count), 0);
        repeat (5) @(negedge clk);
        chk("R6 sticky", 32'(underflow), 1);
        underflow_clr = 1'b1;
        @(negedge clk);
        underflow_clr = 1'b0;
        @(negedge clk);
        chk("R6 clear", 32'(underflow), 0);

        // R2 full, R3 order over full depth
        for (int i = 0; i < DEPTH; i++) push(8'(8'h40 + i));
        push(8'hEE);
        chk("R2 count full", 32'(fifo_count), DEPTH);
        chk("R2 full", 32'(fifo_full), 1);
        for (int i = 0; i < DEPTH; i++) begin
            pulse(0);
            chk("R3 drain", 32'(dio_out), 32'(8'h40 + i));
        end
        chk("R2 drained", 32'(fifo_empty), 1);

        // R4 falling edge
        falling_sel = 1'b1;
        push(8'h77);
        rise(0);
        chk("R4 rise ignored", 32'(dio_out), 32'h4F);
        fall(0);
        chk("R4 fall used", 32'(dio_out), 32'h77);
        falling_sel = 1'b0;
        settle();

        // R5 source selection
        clk_sel = SELW'(5);
        push(8'h88);
        pulse(2);
        chk("R5 unselected", 32'(dio_out), 32'h77);
        chk("R5 count kept", 32'(fifo_count), 1);
        pulse(5);
        chk("R5 external", 32'(dio_out), 32'h88);
        clk_sel = SELW'(3);
        push(8'h99);
        pulse(5);
        chk("R5 ext unselected", 32'(dio_out), 32'h88);
        pulse(3);
        chk("R5 internal 3", 32'(dio_out), 32'h99);

        // R10 idle ignores events
        run = 1'b0;
        settle();
        push(8'hA1);
        pulse(3);
        chk("R10 idle out", 32'(dio_out), 32'h99);
        chk("R10 idle count", 32'(fifo_count), 1);
        chk("R10 idle no uf", 32'(underflow), 0);

        // R7 replay loop
        push(8'hA2); push(8'hA3);
        retransmit = 1'b1;
        run = 1'b1;
        settle();
        for (int i = 0; i < 7; i++) begin
            pulse(3);
            chk("R7 loop", 32'(dio_out), 32'(8'hA1 + (i % 3)));
        end
        chk("R7 count", 32'(fifo_count), 3);

        // R8 writes blocked, data retained
        push(8'hEE);
        chk("R8 write ignored", 32'(fifo_count), 3);
        pulse(3);
        chk("R8 seq A2", 32'(dio_out), 32'hA2);
        pulse(3);
        chk("R8 seq A3", 32'(dio_out), 32'hA3);
        pulse(3);
        chk("R8 wraps past no EE", 32'(dio_out), 32'hA1);
        run = 1'b0;
        retransmit = 1'b0;
        settle();
        run = 1'b1;
        settle();
        for (int i = 0; i < 3; i++) begin
            pulse(3);
            chk("R8 stream retained", 32'(dio_out), 32'(8'hA1 + i));
        end
        chk("R8 drained", 32'(fifo_count), 0);

        // R10 replay requested on empty FIFO waits in idle
        run = 1'b0;
        settle();
        retransmit = 1'b1;
        run = 1'b1;
        settle();
        pulse(3);
        chk("R10 wait no uf", 32'(underflow), 0);
        chk("R10 wait out", 32'(dio_out), 32'hA3);
        push(8'hB5);
        settle();
        pulse(3);
        chk("R10 replay one", 32'(dio_out), 32'hB5);
        pulse(3);
        chk("R7 single wrap", 32'(dio_out), 32'hB5);
        chk("R7 single count", 32'(fifo_count), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule